// File: doc/BRIEF.md
# Indexed predicate select unit

This unit decodes and executes one vector-predicate select operation for a vector length fixed at build time. Each cycle it may take one 32-bit instruction word together with a 32-bit scalar index, a first source predicate and a second source predicate, each VL/8 bits wide. It adds an immediate taken from the instruction to the scalar. It reduces the sum modulo the number of elements for the decoded element size. It then tests that element in the second predicate. The destination receives the first predicate unchanged when the element is active, or all zeros when it is not.

The register-number fields (destination, both predicate sources and the scalar select register) are exposed at once, so a surrounding pipeline can drive its register-file read ports. The result, the write-enable, the destination number and an undefined-instruction flag appear one cycle after the instruction is presented. The operation never touches condition flags. An input pin stands in for the feature enable.

Top module: `psel_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `res_valid`, `res_we`, `res_undef`, `res_dst` and `res_data` are all zero.
- R2: The instruction matches only when insn[31:24]=8'h25, insn[21]=1, insn[15:14]=2'b01, insn[9]=0 and insn[4]=0. Without a match, or with `insn_valid` low, the next cycle shows `res_valid`, `res_we` and `res_undef` low.
- R3: The size field is {insn[22], insn[20:18]} and imm5 is {insn[23], size field}. 1000 selects 64-bit elements with imm=imm5[4]. ?100 selects 32-bit with imm=imm5[4:3]. ??10 selects 16-bit with imm=imm5[4:2]. ???1 selects 8-bit with imm=imm5[4:1].
- R4: A matched instruction whose size field is 0000, or any matched instruction while `feat_en` is low, gives `res_undef`=1 and `res_we`=0.
- R5: The tested element is (idx_val + imm) modulo (VL/esize), taken over the full unsigned sum. With idx_val=32'hFFFFFFFF the sum wraps to a small element number.
- R6: An element is active when pm bit element*(esize/8) is set. The other bits of that element's byte group have no effect.
- R7: A defined instruction gives `res_we`=1 and `res_dst`=insn[3:0]. `res_data` equals `pn_bits` when the tested element is active, and zero otherwise.
- R8: `pn_num`=insn[13:10], `pm_num`=insn[8:5] and `idx_reg`=12+insn[17:16] follow the instruction combinationally.
- R9: Results appear exactly one clock after the inputs are sampled, and `res_data` is zero whenever `res_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Feature enable; low makes a matching instruction undefined |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word |
| idx_val | input | 32 | Scalar index value read from the select register |
| pn_bits | input | VL/8 | First source predicate |
| pm_bits | input | VL/8 | Second source predicate (tested) |
| pn_num | output | 4 | First source predicate number |
| pm_num | output | 4 | Second source predicate number |
| idx_reg | output | 5 | Scalar register number to read (12..15) |
| res_valid | output | 1 | A matching instruction was accepted |
| res_we | output | 1 | Destination predicate write-enable |
| res_undef | output | 1 | Instruction is undefined |
| res_dst | output | 4 | Destination predicate number |
| res_data | output | VL/8 | Value to write to the destination |

## Verification
Two functions can meet in one cycle: the modulo wrap of the index sum and the size-dependent choice of which pm bit stands for the element. Both are provoked together by indices just below and far above the element count, including 32'hFFFFFFFF plus a nonzero immediate, for every element size. The pm patterns set only the non-leading bits of a group, or only the leading bit. Each result is judged against a reference model in the bench that computes the element, the bit position and the selected value from the requirements.

// File: rtl/psel_pkg.sv
package psel_pkg;
    localparam logic [7:0] OPC_TOP = 8'h25;

    typedef struct packed {
        logic       match;
        logic       undef;
        logic [1:0] lg_esz;   // log2(esize/8)
        logic [3:0] imm;
        logic [3:0] pd;
    } dec_t;
endpackage

// File: rtl/psel_decode.sv
module psel_decode
    import psel_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        feat_en,
    output dec_t        dec,
    output logic [3:0]  pn_num,
    output logic [3:0]  pm_num,
    output logic [4:0]  idx_reg
);
    logic [3:0] size_fld;
    logic       i1;

    assign size_fld = {insn[22], insn[20:18]};
    assign i1       = insn[23];

    always_comb begin
        dec.match = (insn[31:24] == OPC_TOP) && insn[21] && (insn[15:14] == 2'b01)
                    && !insn[9] && !insn[4];
        dec.pd    = insn[3:0];
        dec.undef = !feat_en;
        casez (size_fld)
            4'b1000: begin dec.lg_esz = 2'd3; dec.imm = {3'b000, i1}; end
            4'b?100: begin dec.lg_esz = 2'd2; dec.imm = {2'b00, i1, size_fld[3]}; end
            4'b??10: begin dec.lg_esz = 2'd1; dec.imm = {1'b0, i1, size_fld[3:2]}; end
            4'b???1: begin dec.lg_esz = 2'd0; dec.imm = {i1, size_fld[3:1]}; end
            default: begin dec.lg_esz = 2'd0; dec.imm = 4'd0; dec.undef = 1'b1; end
        endcase
    end

    assign pn_num  = insn[13:10];
    assign pm_num  = insn[8:5];
    assign idx_reg = 5'd12 + {3'b000, insn[17:16]};
endmodule

// File: rtl/psel_index.sv
module psel_index #(
    parameter int LG_PW = 5
) (
    input  logic [31:0]      idx_val,
    input  logic [3:0]       imm,
    input  logic [1:0]       lg_esz,
    output logic [LG_PW-1:0] bit_pos
);
    logic [32:0]      sum;
    logic [LG_PW-1:0] mask;
    logic [LG_PW-1:0] elem;

    always_comb begin
        sum     = {1'b0, idx_val} + {29'd0, imm};
        mask    = {LG_PW{1'b1}} >> lg_esz;          // element count - 1
        elem    = sum[LG_PW-1:0] & mask;
        bit_pos = elem << lg_esz;                   // lead bit of the byte group
    end
endmodule

// File: rtl/psel_pick.sv
module psel_pick #(
    parameter int PW    = 32,
    parameter int LG_PW = 5
) (
    input  logic [PW-1:0]    pm_bits,
    input  logic [LG_PW-1:0] bit_pos,
    output logic             hit
);
    assign hit = pm_bits[bit_pos];
endmodule

// File: rtl/psel_unit.sv
module psel_unit
    import psel_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            feat_en,
    input  logic            insn_valid,
    input  logic [31:0]     insn,
    input  logic [31:0]     idx_val,
    input  logic [VL/8-1:0] pn_bits,
    input  logic [VL/8-1:0] pm_bits,
    output logic [3:0]      pn_num,
    output logic [3:0]      pm_num,
    output logic [4:0]      idx_reg,
    output logic            res_valid,
    output logic            res_we,
    output logic            res_undef,
    output logic [3:0]      res_dst,
    output logic [VL/8-1:0] res_data
);
    localparam int PW    = VL / 8;
    localparam int LG_PW = $clog2(PW);

    typedef struct packed {
        logic          valid;
        logic          we;
        logic          undef;
        logic [3:0]    dst;
        logic [PW-1:0] data;
    } res_t;

    dec_t             dec;
    logic [LG_PW-1:0] bit_pos;
    logic             hit;
    res_t             st_d, st_q;

    psel_decode u_dec (
        .insn(insn), .feat_en(feat_en), .dec(dec),
        .pn_num(pn_num), .pm_num(pm_num), .idx_reg(idx_reg)
    );

    psel_index #(.LG_PW(LG_PW)) u_idx (
        .idx_val(idx_val), .imm(dec.imm), .lg_esz(dec.lg_esz), .bit_pos(bit_pos)
    );

    psel_pick #(.PW(PW), .LG_PW(LG_PW)) u_pick (
        .pm_bits(pm_bits), .bit_pos(bit_pos), .hit(hit)
    );

    always_comb begin
        st_d = '0;
        if (insn_valid && dec.match) begin
            st_d.valid = 1'b1;
            st_d.undef = dec.undef;
            if (!dec.undef) begin
                st_d.we   = 1'b1;
                st_d.dst  = dec.pd;
                st_d.data = hit ? pn_bits : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_we    = st_q.we;
    assign res_undef = st_q.undef;
    assign res_dst   = st_q.dst;
    assign res_data  = st_q.data;
endmodule

module psel_unit_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_valid,
    input logic [31:0]   insn,
    input logic [PW-1:0] pn_bits,
    input logic          res_valid,
    input logic          res_we,
    input logic          res_undef,
    input logic [3:0]    res_dst,
    input logic [PW-1:0] res_data
);
    assert_undef_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_undef |-> !res_we);

    assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_we && !res_undef));

    assert_idle_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !res_valid);

    assert_zero_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |-> (res_data == '0));

    assert_pass_or_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> (!res_we || res_data == '0 || res_data == $past(pn_bits)));

    assert_dst_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> (!res_we || res_dst == $past(insn[3:0])));
endmodule

bind psel_unit psel_unit_chk #(.PW(VL/8)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .pn_bits(pn_bits),
    .res_valid(res_valid), .res_we(res_we), .res_undef(res_undef),
    .res_dst(res_dst), .res_data(res_data)
);

// File: tb/psel_unit_tb.sv
module psel_unit_tb;
    localparam int VL = 256;
    localparam int PW = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          feat_en = 1'b1;
    logic          insn_valid = 1'b0;
    logic [31:0]   insn = '0;
    logic [31:0]   idx_val = '0;
    logic [PW-1:0] pn_bits = '0;
    logic [PW-1:0] pm_bits = '0;
    logic [3:0]    pn_num, pm_num;
    logic [4:0]    idx_reg;
    logic          res_valid, res_we, res_undef;
    logic [3:0]    res_dst;
    logic [PW-1:0] res_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    psel_unit #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .insn_valid(insn_valid),
        .insn(insn), .idx_val(idx_val), .pn_bits(pn_bits), .pm_bits(pm_bits),
        .pn_num(pn_num), .pm_num(pm_num), .idx_reg(idx_reg),
        .res_valid(res_valid), .res_we(res_we), .res_undef(res_undef),
        .res_dst(res_dst), .res_data(res_data)
    );

    function automatic logic [31:0] mk(input logic i1, input logic [3:0] sz,
                                       input logic [1:0] rv, input logic [3:0] pn,
                                       input logic [3:0] pm, input logic [3:0] pd);
        return {8'h25, i1, sz[3], 1'b1, sz[2:0], rv, 2'b01, pn, 1'b0, pm, 1'b0, pd};
    endfunction

    // Reference: expected active bit of pm per R3, R5, R6
    function automatic logic ref_hit(input logic i1, input logic [3:0] sz,
                                     input logic [31:0] idx, input logic [PW-1:0] pm);
        int esize, imm;
        longint elems, e;
        logic [4:0] imm5;
        imm5 = {i1, sz};
        if (sz == 4'b1000)    begin esize = 64; imm = int'(imm5[4]);   end
        else if (sz[1:0] == 2'b00) begin esize = 32; imm = int'(imm5[4:3]); end
        else if (sz[0] == 1'b0)    begin esize = 16; imm = int'(imm5[4:2]); end
        else                       begin esize = 8;  imm = int'(imm5[4:1]); end
        elems = longint'(VL / esize);
        e = (longint'(idx) + longint'(imm)) % elems;
        return pm[int'(e) * (esize / 8)];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at negedge, check one clock later (at next negedge) - R9
    task automatic run(input logic [31:0] w, input logic [31:0] idx,
                       input logic [PW-1:0] pn, input logic [PW-1:0] pm,
                       input logic fe, input logic vld);
        @(negedge clk);
        insn = w; idx_val = idx; pn_bits = pn; pm_bits = pm;
        feat_en = fe; insn_valid = vld;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic run_def(input string req, input logic i1, input logic [3:0] sz,
                           input logic [31:0] idx, input logic [PW-1:0] pn,
                           input logic [PW-1:0] pm, input logic [3:0] pd);
        logic h;
        h = ref_hit(i1, sz, idx, pm);
        run(mk(i1, sz, 2'd0, 4'd1, 4'd2, pd), idx, pn, pm, 1'b1, 1'b1);
        chk({req, " we"},   64'(res_we), 64'd1);
        chk({req, " dst"},  64'(res_dst), 64'(pd));
        chk({req, " data"}, 64'(res_data), h ? 64'(pn) : 64'd0);
    endtask

    // Table: {i1, size, idx, pm}
    localparam int NV = 10;
    localparam logic [68:0] VECS [NV] = '{
        {1'b0, 4'b0001, 32'd0,          32'h0000_0001},
        {1'b1, 4'b0001, 32'd31,         32'h0000_0080},
        {1'b0, 4'b0010, 32'd15,         32'h4000_0000},
        {1'b1, 4'b0110, 32'd14,         32'h0000_0004},
        {1'b0, 4'b0100, 32'd7,          32'h1000_0000},
        {1'b1, 4'b1100, 32'd6,          32'h0000_0010},
        {1'b0, 4'b1000, 32'd3,          32'h0100_0000},
        {1'b1, 4'b1000, 32'd3,          32'h0000_0001},
        {1'b1, 4'b1111, 32'hFFFF_FFFF,  32'h0000_0080},
        {1'b0, 4'b1000, 32'hFFFF_FFFF,  32'hFEFE_FEFE}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 valid", 64'(res_valid), 0);
        chk("R1 we",    64'(res_we), 0);
        chk("R1 data",  64'(res_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({res_valid, res_we, res_undef, res_dst}), 0);

        // R8: read-port numbers
        insn = mk(1'b0, 4'b0001, 2'd3, 4'd9, 4'd14, 4'd5);
        #1;
        chk("R8 pn_num",  64'(pn_num), 64'd9);
        chk("R8 pm_num",  64'(pm_num), 64'd14);
        chk("R8 idx_reg", 64'(idx_reg), 64'd15);

        // R3 R5 R6 R7: vector table
        for (int k = 0; k < NV; k++) begin
            run_def("R5_R6 table", VECS[k][68], VECS[k][67:64], VECS[k][63:32],
                    32'hA5C3_0F96 ^ PW'(k), VECS[k][31:0], 4'(k));
        end

        // R6: non-lead bits of 64-bit group ignored (element 0, bits 1..7)
        run_def("R6 ignored bits", 1'b0, 4'b1000, 32'd0, 32'h1234_5678, 32'h0000_00FE, 4'd7);
        chk("R6 zero result", 64'(res_data), 64'd0);

        // R5: overflow past 2^32, 8-bit, imm=15 -> element 14
        run_def("R5 overflow", 1'b1, 4'b1111, 32'hFFFF_FFFF, 32'hCAFE_F00D, 32'h0000_4000, 4'd3);
        chk("R5 overflow hit", 64'(res_data), 64'hCAFE_F00D);

        // R2: opcode mismatch (bit 21 cleared)
        run(mk(1'b0, 4'b0001, 2'd0, 4'd1, 4'd2, 4'd4) & ~32'h0020_0000, 32'd0, '1, '1, 1'b1, 1'b1);
        chk("R2 mismatch", 64'({res_valid, res_we, res_undef}), 0);
        chk("R9 data zero", 64'(res_data), 0);
        // R2: insn_valid low
        run(mk(1'b0, 4'b0001, 2'd0, 4'd1, 4'd2, 4'd4), 32'd0, '1, '1, 1'b1, 1'b0);
        chk("R2 not valid", 64'({res_valid, res_we, res_undef}), 0);

        // R4: size 0000 and feature off
        run(mk(1'b1, 4'b0000, 2'd0, 4'd1, 4'd2, 4'd4), 32'd0, '1, '1, 1'b1, 1'b1);
        chk("R4 size0", 64'({res_valid, res_we, res_undef}), 64'b101);
        run(mk(1'b0, 4'b0001, 2'd0, 4'd1, 4'd2, 4'd4), 32'd0, '1, '1, 1'b0, 1'b1);
        chk("R4 feat off", 64'({res_valid, res_we, res_undef}), 64'b101);
        chk("R4 data", 64'(res_data), 0);

        // R9: latency - result not yet present half a cycle after drive
        @(negedge clk);
        insn = mk(1'b0, 4'b0001, 2'd0, 4'd1, 4'd2, 4'd6); idx_val = 0;
        pn_bits = 32'h55; pm_bits = 32'h1; feat_en = 1'b1; insn_valid = 1'b1;
        #1;
        chk("R9 before edge", 64'(res_we), 0);
        @(negedge clk);
        insn_valid = 1'b0;
        chk("R9 after edge", 64'(res_data), 64'h55);

        // R3 R5 R7: random against reference
        for (int k = 0; k < 300; k++) begin
            logic [3:0] sz;
            sz = 4'($urandom_range(1, 15));
            run_def("R3_R7 random", 1'($urandom), sz, $urandom, PW'($urandom),
                    PW'($urandom), 4'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule